// File: doc/BRIEF.md
# Switch-Programmable Sample-Rate Divider

This block sets the sampling rate of a pulse-width DAC. It divides a fast system clock by a ratio chosen on an 8-bit switch bank. It does not make a second clock. Instead it emits a one-cycle enable pulse in the system clock domain, so every downstream register stays on the one clock. The switch bank drives only the high part of a wider terminal count. The low bits are held at zero, so a few switches still cover a range from every clock cycle down to about 1.5 kHz at a 50 MHz input.

The switches come from an external debouncer. They are still asynchronous to the clock, so they pass through a two-flop synchronizer. A new setting takes effect only when the current period ends. The block also reports the length of the period now running. The number of switch bits and the number of tied-off low bits are parameters, so a short configuration can be simulated quickly.

Top module: `rate_divider`

## Requirements
- R1: With switch value S, consecutive `sample_en` pulses are N = S·2^LOW_W + 1 clock cycles apart. S occupies the upper SW_W bits of the terminal count and the LOW_W low bits are zero.
- R2: With S = 0, `sample_en` is high on every clock cycle (N = 1).
- R3: With every switch bit set, the spacing is the slowest one, (2^SW_W − 1)·2^LOW_W + 1 cycles.
- R4: When N > 1, `sample_en` is high for exactly one cycle per period.
- R5: A switch change during a period does not shorten or lengthen that period. The new spacing starts at a period boundary.
- R6: Switch inputs pass through a two-flop synchronizer. A change made one cycle before a boundary is not used at that boundary, only at the following one.
- R7: While `rst` is high, `sample_en` is low. After `rst` falls, the first pulse appears N cycles later, where N comes from the switch value present during reset.
- R8: `cur_period` reports N for the period in progress and changes only at a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw | input | SW_W | Debounced rate setting |
| sample_en | output | 1 | One-cycle sampling strobe |
| cur_period | output | SW_W+LOW_W | Length in cycles of the current period |

## Verification
The bench runs a table of switch settings through the spacing measurement. Zero tells apart the pass-through case from an off-by-one counter. A setting of one separates the position of the tied-off bits from a plain shift. A mid value and the top bit alone expose wrong bit weighting. All ones checks the slowest end without overflow. Directed cases then change the switches in mid-period and one cycle before a boundary. These separate a design that latches the setting at the boundary, through the synchronizer, from one that reloads at once or skips the synchronizer. A reset case checks the time to the first pulse.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam int SRD_SW_W  = 8;
  localparam int SRD_LOW_W = 7;
endpackage

// File: rtl/srd_sw_sync.sv
module srd_sw_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  // During reset both stages take the raw value so the first setting is ready at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= d;
      q      <= d;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/srd_period_latch.sv
module srd_period_latch #(
  parameter int SW_W  = 8,
  parameter int LOW_W = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [SW_W-1:0]       setting,
  output logic [SW_W+LOW_W-1:0] term,
  output logic [SW_W+LOW_W-1:0] period
);
  localparam int CNT_W = SW_W + LOW_W;

  logic [CNT_W-1:0] next_term;
  assign next_term = {setting, {LOW_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || load) begin
      term   <= next_term;
      period <= next_term + CNT_W'(1);
    end
  end

  assert_hold_midperiod_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(term));
  assert_period_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(period));
endmodule

// File: rtl/srd_rate_counter.sv
module srd_rate_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] term,
  output logic             wrap,
  output logic             strobe
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap = (cnt_q == term);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      strobe <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      strobe <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      strobe <= 1'b0;
    end
  end

  assert_count_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= term);
  assert_strobe_at_restart_R4: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (cnt_q == '0));
  assert_quiet_in_reset_R7: assert property (@(posedge clk)
    rst |=> !strobe);
endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int SW_W  = srd_pkg::SRD_SW_W,
  parameter int LOW_W = srd_pkg::SRD_LOW_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SW_W-1:0]       sw,
  output logic                  sample_en,
  output logic [SW_W+LOW_W-1:0] cur_period
);
  localparam int CNT_W = SW_W + LOW_W;

  logic [SW_W-1:0]  sw_s;
  logic [SW_W-1:0]  setting;
  logic [CNT_W-1:0] term;
  logic             wrap;

  srd_sw_sync #(.W(SW_W)) u_sync (
    .clk(clk), .rst(rst), .d(sw), .q(sw_s)
  );

  // In reset the period loads straight from the pins, as the synchronizer does.
  assign setting = rst ? sw : sw_s;

  srd_period_latch #(.SW_W(SW_W), .LOW_W(LOW_W)) u_latch (
    .clk(clk), .rst(rst), .load(wrap), .setting(setting),
    .term(term), .period(cur_period)
  );

  srd_rate_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .term(term), .wrap(wrap), .strobe(sample_en)
  );
endmodule

// File: tb/rate_divider_bench.sv
module rate_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW_W  = 8;
  localparam int LOW_W = 3;
  localparam int CNT_W = SW_W + LOW_W;
  localparam int NVEC  = 5;
  localparam logic [SW_W-1:0] VEC_SW [NVEC] = '{8'd0, 8'd1, 8'd5, 8'h80, 8'hFF};
  localparam int              VEC_N  [NVEC] = '{1, 9, 41, 1025, 2041};
  localparam string           VEC_R  [NVEC] = '{"R2", "R1", "R1", "R1", "R3"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW_W-1:0] sw = '0;
  logic sample_en;
  logic [CNT_W-1:0] cur_period;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_divider #(.SW_W(SW_W), .LOW_W(LOW_W)) u_rate_divider (
    .clk(clk), .rst(rst), .sw(sw), .sample_en(sample_en), .cur_period(cur_period)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at the negedge where a pulse was seen; returns cycles to the next pulse.
  task automatic to_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sample_en && n < 5000);
  endtask

  initial begin
    int n;
    int ones;
    // Reset state, R7
    sw = 8'd2;
    repeat (3) @(negedge clk);
    check("R7 reset strobe low", sample_en, 0);
    check("R8 period at reset", cur_period, 17);
    rst = 1'b0;
    to_strobe(n);
    check("R7 first pulse delay", n, 17);

    // Table of settings: R1, R2, R3, R8
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      sw = VEC_SW[i];
      for (int k = 0; k < 3; k++) to_strobe(n);
      to_strobe(n);
      check(VEC_R[i], n, VEC_N[i]);
      check("R8 cur_period", cur_period, VEC_N[i]);
    end

    // R2: strobe high continuously at zero setting
    @(negedge clk);
    sw = 8'd0;
    for (int k = 0; k < 3; k++) to_strobe(n);
    ones = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      ones += int'(sample_en);
    end
    check("R2 continuous", ones, 6);

    // R4: single-cycle pulse
    sw = 8'd5;
    for (int k = 0; k < 3; k++) to_strobe(n);
    @(negedge clk);
    check("R4 pulse width", sample_en, 0);
    to_strobe(n);

    // R5: change in mid-period keeps the period length
    repeat (10) @(negedge clk);
    sw = 8'd1;
    to_strobe(n);
    check("R5 period kept", n + 10, 41);
    to_strobe(n);
    check("R5 new period", n, 9);
    check("R8 updated", cur_period, 9);

    // R6: change one cycle before a boundary waits one more period
    repeat (8) @(negedge clk);
    sw = 8'd2;
    @(negedge clk);
    check("R6 boundary pulse", sample_en, 1);
    to_strobe(n);
    check("R6 old period kept", n, 9);
    to_strobe(n);
    check("R6 new period", n, 17);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule